// File: doc/BRIEF.md
# Four-Lane Vector Lane Permutation Unit

This unit rearranges the lanes of 4-lane vectors of 32-bit elements. Each operation takes two source vectors, an 8-bit lane selector, a sub-vector length and a 3-bit operation code. The registered result appears one clock later. The unit provides five kinds of operation: a straight copy of the first source, a single-source swizzle, a two-source shuffle, and interleaves at 32-bit and 64-bit granularity. One routing stage drives every operation. That stage decides, for each output lane, whether the lane reads the first source or the second source, which source lane it reads, or whether it is forced to zero.

A 4x4 matrix held as four row vectors can be transposed in two rounds of four operations. The first round applies four 32-bit interleaves, and the second applies four 64-bit interleaves. A caller starts an operation by raising `in_valid` for one cycle with the operands present. The result is captured on that clock edge and is flagged by `out_valid`. The result register keeps its value while no new operation is issued.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is high, and after it is released, `out_valid` reads 0 and `result` reads all zeros until the first operation is accepted.
- R2: Op code 0 (copy) returns `src_a` unchanged.
- R3: Op code 1 (swizzle) with a nonzero `subvl` sets output lane k to `src_a` lane `sel[2k+1:2k]`. Lane 0 (x) uses bits 1:0, lane 1 (y) bits 3:2, lane 2 (z) bits 5:4 and lane 3 (w) bits 7:6. Lane k occupies bits 32k+31:32k.
- R4: Op code 1 with `subvl` equal to zero returns `src_a` unchanged, whatever the value of `sel`.
- R5: Op code 2 (shuffle) sets output lanes 0 and 1 to `src_a` lanes `sel[1:0]` and `sel[3:2]`, and output lanes 2 and 3 to `src_b` lanes `sel[5:4]` and `sel[7:6]`.
- R6: A shuffle whose two sources are equal and whose four selector fields all equal i places lane i in every output lane.
- R7: Op code 3 returns lanes {a0, b0, a1, b1} and op code 4 returns {a2, b2, a3, b3}, listed from lane 0 upward.
- R8: Op code 5 returns lanes {a0, a1, b0, b1} and op code 6 returns {a2, a3, b2, b3}, listed from lane 0 upward.
- R9: Op code 7 returns an all-zero result.
- R10: Operands are sampled on the rising edge at which `in_valid` is high. The result and `out_valid`=1 are visible after that same edge. After an edge at which `in_valid` is low, `out_valid` is 0 and `result` keeps its previous value.
- R11: Applying ops 3, 3, 4, 4 to the row pairs (0,1), (2,3), (0,1), (2,3), and then ops 5, 6, 5, 6 to the intermediate pairs (T0,T1), (T0,T1), (T2,T3), (T2,T3), yields the transpose of the 4x4 matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 3 | Operation code (0 to 7) |
| sel | input | 8 | Four 2-bit lane selectors |
| subvl | input | SVL_W (2) | Sub-vector length; zero disables the swizzle |
| src_a | input | 4*EW (128) | First source vector, lane 0 in the low bits |
| src_b | input | 4*EW (128) | Second source vector |
| out_valid | output | 1 | Result was captured on the previous edge |
| result | output | 4*EW (128) | Registered permuted vector |

## Verification
The properties assume that `op`, `sel`, `subvl` and both sources are stable and known around every rising edge at which `in_valid` is high. They also assume that reset is applied synchronously for at least one edge before the first operation. The bench changes every input only on the falling clock edge and drives `in_valid` for one cycle per operation, so these assumptions always hold. Random operands are drawn across all eight op codes, with a zero `subvl` about a quarter of the time. Directed cases cover the broadcast, the hold behaviour and the full transpose.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
  localparam int LANES = 4;
  localparam int IDX_W = $clog2(LANES);
  localparam int SEL_W = LANES * IDX_W;

  typedef enum logic [2:0] {
    OP_COPY    = 3'd0,
    OP_SWIZZLE = 3'd1,
    OP_SHUFFLE = 3'd2,
    OP_ILV_L32 = 3'd3,
    OP_ILV_H32 = 3'd4,
    OP_ILV_L64 = 3'd5,
    OP_ILV_H64 = 3'd6,
    OP_ZERO    = 3'd7
  } lpu_op_e;

  typedef struct packed {
    logic             kill;
    logic             use_b;
    logic [IDX_W-1:0] idx;
  } lane_route_t;
endpackage

// File: rtl/lpu_route_ctrl.sv
module lpu_route_ctrl
  import lpu_pkg::*;
(
  input  logic [2:0]                    op,
  input  logic [SEL_W-1:0]              sel,
  input  logic                          svl_nz,
  output lane_route_t [LANES-1:0]       route
);
  localparam int HALF = LANES / 2;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      route[k].kill  = 1'b0;
      route[k].use_b = 1'b0;
      route[k].idx   = IDX_W'(k);
    end
    unique case (lpu_op_e'(op))
      OP_COPY: ;
      OP_SWIZZLE: begin
        if (svl_nz) begin
          for (int k = 0; k < LANES; k++)
            route[k].idx = sel[k*IDX_W +: IDX_W];
        end
      end
      OP_SHUFFLE: begin
        for (int k = 0; k < LANES; k++) begin
          route[k].idx   = sel[k*IDX_W +: IDX_W];
          route[k].use_b = (k >= HALF);
        end
      end
      OP_ILV_L32, OP_ILV_H32: begin
        for (int k = 0; k < LANES; k++) begin
          route[k].use_b = k[0];
          route[k].idx   = IDX_W'((k >> 1) + ((op == OP_ILV_H32) ? HALF : 0));
        end
      end
      OP_ILV_L64, OP_ILV_H64: begin
        for (int k = 0; k < LANES; k++) begin
          route[k].use_b = k[1];
          route[k].idx   = IDX_W'((k & 1) + ((op == OP_ILV_H64) ? HALF : 0));
        end
      end
      default: begin
        for (int k = 0; k < LANES; k++)
          route[k].kill = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lpu_lane_mux.sv
module lpu_lane_mux
  import lpu_pkg::*;
#(
  parameter int EW = 32
) (
  input  lane_route_t          route,
  input  logic [LANES*EW-1:0]  src_a,
  input  logic [LANES*EW-1:0]  src_b,
  output logic [EW-1:0]        lane
);
  logic [EW-1:0] from_a;
  logic [EW-1:0] from_b;

  always_comb begin
    from_a = src_a[route.idx*EW +: EW];
    from_b = src_b[route.idx*EW +: EW];
    if (route.kill)       lane = '0;
    else if (route.use_b) lane = from_b;
    else                  lane = from_a;
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lpu_pkg::*;
#(
  parameter int EW    = 32,
  parameter int SVL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [SEL_W-1:0]     sel,
  input  logic [SVL_W-1:0]     subvl,
  input  logic [LANES*EW-1:0]  src_a,
  input  logic [LANES*EW-1:0]  src_b,
  output logic                 out_valid,
  output logic [LANES*EW-1:0]  result
);
  localparam int VW = LANES * EW;

  lane_route_t [LANES-1:0] route;
  logic [VW-1:0]           permuted;

  lpu_route_ctrl u_ctrl (
    .op     (op),
    .sel    (sel),
    .svl_nz (|subvl),
    .route  (route)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lpu_lane_mux #(.EW(EW)) u_mux (
      .route (route[g]),
      .src_a (src_a),
      .src_b (src_b),
      .lane  (permuted[g*EW +: EW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= permuted;
    end
  end
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker
  import lpu_pkg::*;
#(
  parameter int EW    = 32,
  parameter int SVL_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [2:0]           op,
  input logic [SEL_W-1:0]     sel,
  input logic [SVL_W-1:0]     subvl,
  input logic [LANES*EW-1:0]  src_a,
  input logic [LANES*EW-1:0]  src_b,
  input logic                 out_valid,
  input logic [LANES*EW-1:0]  result
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  a_r2_copy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_COPY) |=> result == $past(src_a));

  a_r4_swizzle_off: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SWIZZLE && subvl == '0) |=> result == $past(src_a));

  a_r6_broadcast: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SHUFFLE && sel == '0 && src_a == src_b)
      |=> (result[EW-1:0] == $past(src_a[EW-1:0]) &&
           result[2*EW-1:EW] == result[EW-1:0] &&
           result[3*EW-1:2*EW] == result[EW-1:0] &&
           result[4*EW-1:3*EW] == result[EW-1:0]));

  a_r9_zero_op: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ZERO) |=> result == '0);
endmodule

bind lane_permute_unit lpu_checker #(.EW(EW), .SVL_W(SVL_W)) u_lpu_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .sel       (sel),
  .subvl     (subvl),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/test_lane_permute_unit.sv
`timescale 1ns/1ps
module test_lane_permute_unit;
  localparam int EW = 32;
  localparam int VW = 4 * EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    op = '0;
  logic [7:0]    sel = '0;
  logic [1:0]    subvl = '0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic          out_valid;
  logic [VW-1:0] result;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lane_permute_unit #(.EW(EW), .SVL_W(2)) i_lane_permute_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .sel(sel),
    .subvl(subvl), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [EW-1:0] ln(logic [VW-1:0] v, int i);
    return v[i*EW +: EW];
  endfunction

  function automatic logic [VW-1:0] pack4(logic [EW-1:0] l0, logic [EW-1:0] l1,
                                          logic [EW-1:0] l2, logic [EW-1:0] l3);
    return {l3, l2, l1, l0};
  endfunction

  function automatic logic [VW-1:0] ref_model(logic [2:0] o, logic [7:0] s,
      logic [1:0] v, logic [VW-1:0] a, logic [VW-1:0] b);
    case (o)
      3'd0: return a;
      3'd1: return (v == 0) ? a :
                   pack4(ln(a, s[1:0]), ln(a, s[3:2]), ln(a, s[5:4]), ln(a, s[7:6]));
      3'd2: return pack4(ln(a, s[1:0]), ln(a, s[3:2]), ln(b, s[5:4]), ln(b, s[7:6]));
      3'd3: return pack4(ln(a,0), ln(b,0), ln(a,1), ln(b,1));
      3'd4: return pack4(ln(a,2), ln(b,2), ln(a,3), ln(b,3));
      3'd5: return pack4(ln(a,0), ln(a,1), ln(b,0), ln(b,1));
      3'd6: return pack4(ln(a,2), ln(a,3), ln(b,2), ln(b,3));
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] o, logic [1:0] v);
    case (o)
      3'd0: return "R2";
      3'd1: return (v == 0) ? "R4" : "R3";
      3'd2: return "R5";
      3'd3, 3'd4: return "R7";
      3'd5, 3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive on the falling edge, capture at the rising edge, sample at the next falling edge.
  task automatic apply(input logic [2:0] o, input logic [7:0] s, input logic [1:0] v,
                       input logic [VW-1:0] a, input logic [VW-1:0] b,
                       output logic [VW-1:0] got);
    in_valid = 1'b1; op = o; sel = s; subvl = v; src_a = a; src_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got = result;
    check("R10 out_valid", {127'd0, out_valid}, {127'd0, 1'b1});
    check(req_of(o, v), got, ref_model(o, s, v, a, b));
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] got;
    logic [VW-1:0] held;
    logic [VW-1:0] rows [4];
    logic [VW-1:0] t [4];
    logic [VW-1:0] o [4];
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {127'd0, out_valid}, '0);
    check("R1 result in reset", result, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {127'd0, out_valid}, '0);
    check("R1 result after reset", result, '0);

    // R6 broadcast of each lane
    for (int i = 0; i < 4; i++) begin
      logic [VW-1:0] a;
      logic [7:0] s;
      a = rnd_vec();
      s = {4{i[1:0]}};
      apply(3'd2, s, 2'd1, a, a, got);
      check("R6 broadcast", got, {4{ln(a, i)}});
    end

    // R4 swizzle disabled with a nonidentity selector
    apply(3'd1, 8'h1B, 2'd0, rnd_vec(), rnd_vec(), got);
    // R3 reversal swizzle, lane 0 takes selector bits 1:0
    apply(3'd1, 8'h1B, 2'd3, pack4(32'hA0, 32'hA1, 32'hA2, 32'hA3), '0, got);
    check("R3 reverse", got, pack4(32'hA3, 32'hA2, 32'hA1, 32'hA0));
    // R9 zero op
    apply(3'd7, 8'hFF, 2'd1, rnd_vec(), rnd_vec(), got);

    // R10 hold with in_valid low and changing inputs
    held = result;
    op = 3'd0; src_a = rnd_vec(); src_b = rnd_vec(); sel = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    check("R10 out_valid idle", {127'd0, out_valid}, '0);
    check("R10 result held", result, held);

    // R11 transpose of a 4x4 matrix
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        rows[r][c*EW +: EW] = 32'h100 * r + c;
    apply(3'd3, 8'h00, 2'd0, rows[0], rows[1], t[0]);
    apply(3'd3, 8'h00, 2'd0, rows[2], rows[3], t[1]);
    apply(3'd4, 8'h00, 2'd0, rows[0], rows[1], t[2]);
    apply(3'd4, 8'h00, 2'd0, rows[2], rows[3], t[3]);
    apply(3'd5, 8'h00, 2'd0, t[0], t[1], o[0]);
    apply(3'd6, 8'h00, 2'd0, t[0], t[1], o[1]);
    apply(3'd5, 8'h00, 2'd0, t[2], t[3], o[2]);
    apply(3'd6, 8'h00, 2'd0, t[2], t[3], o[3]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        check("R11 transpose", {96'd0, ln(o[r], c)}, {96'd0, ln(rows[c], r)});

    // Random mix across every op code
    for (int n = 0; n < 400; n++) begin
      logic [1:0] v;
      v = ($urandom_range(0, 3) == 0) ? 2'd0 : 2'($urandom_range(1, 3));
      apply(3'($urandom_range(0, 7)), 8'($urandom), v, rnd_vec(), rnd_vec(), got);
      if ($urandom_range(0, 4) == 0) begin
        held = result;
        @(posedge clk);
        @(negedge clk);
        check("R10 idle hold", result, held);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule